// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a frame clock and one data line. It acts as a slave. A faster system clock oversamples the link: the bit clock, the frame clock and the data each pass through a two-stage synchroniser, and the block looks for rising edges of the bit clock in the system-clock domain. On each bit-clock rise it takes one data bit and one frame-clock sample.

A static 3-bit format input picks how the words sit in the frame. In left-justified framing the word starts at the frame-clock change. In I2S framing it starts one bit clock after that change. In right-justified framing the word ends at the next change, and the word length is 16, 18, 20 or 24 bits. Each finished channel word leaves the block as a 24-bit value with a channel tag and a one-cycle valid strobe, in the system-clock domain.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and after it is released, `pcm_valid`, `pcm_word` and `pcm_right` are all 0 until the first word is issued.
- R2: `format` decodes as follows: 000 left-justified, 001 I2S, 100 right-justified 24-bit, 101 right-justified 20-bit, 110 right-justified 18-bit, 111 right-justified 16-bit. Codes 010 and 011 behave exactly as left-justified.
- R3: In left-justified mode the data bit taken on the bit-clock rise where a frame-clock change is first seen is the MSB of the new word. Frame clock high marks the left channel. Up to 24 bits are kept, and any later bits in the same half-frame are ignored.
- R4: In left-justified and I2S modes, a half-frame that carries fewer than 24 bits gives a word whose bits sit at the top of `pcm_word`, with zeros below them.
- R5: In I2S mode the MSB is the bit taken one bit-clock rise after the frame-clock change, so the bit taken at the change is the LSB of the word before it. Frame clock low marks the left channel.
- R6: In right-justified mode only the last N bits taken before the next frame-clock change are used, where N is 24, 20, 18 or 16 as set by R2. They are sign-extended from bit N-1 to 24 bits, and the earlier bits of the half-frame are ignored.
- R7: Data is taken on the rising edge of the bit clock. A change on the data line while the bit clock is high does not alter the word.
- R8: Each completed channel word gives exactly one `pcm_valid` pulse, one system clock long. `pcm_right` is 1 for a right-channel word and 0 for a left-channel word, so consecutive words alternate in channel.
- R9: A half-frame whose starting frame-clock change was not seen after reset produces no word. The first word issued is the first channel whose start and end were both seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| frame_clk | input | 1 | Serial left/right frame clock |
| ser_data | input | 1 | Serial data, MSB first |
| format | input | 3 | Static framing select (see R2) |
| pcm_word | output | WORD_W | Last completed channel word |
| pcm_right | output | 1 | Channel tag of `pcm_word`: 1 right, 0 left |
| pcm_valid | output | 1 | One-cycle strobe when `pcm_word` is updated |

## Verification
The bench goes after the point where one word ends and the next begins. A receiver that takes the I2S MSB on the frame-clock change itself, or that drops the LSB arriving with the change, gives words shifted by one bit with a wrong bit at the end. Right-justified runs use negative left words and padding made of ones, so a receiver that keeps the leading bits, that zero-fills instead of sign-extending, or that miscounts N shows up at once. Half-frames of only 16 bit clocks show whether short words are left-aligned with zero fill. A run that starts inside a half-frame shows whether a fragment is issued as a real word. Every data bit is flipped while the bit clock is high, which exposes sampling on the wrong edge. The aliased format code and the pulse width and channel alternation of the strobe are checked as well.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              frame_clk,
  input  logic              ser_data,
  input  logic [2:0]        format,
  output logic [WORD_W-1:0] pcm_word,
  output logic              pcm_right,
  output logic              pcm_valid
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_STAGES:0]   bck_sr, lr_sr, sd_sr;
  logic                   bck_rise, lr_now, bit_now;
  logic                   is_rj, is_i2s;
  logic                   lr_q1, lr_q2, started;
  logic [1:0]             seen;
  logic                   eff_lr, eff_prev, eff_ok, boundary;
  logic [WORD_W-1:0]      head, tail, lj_word, rj_word;
  logic signed [WORD_W-1:0] rj_tmp;
  logic [CNT_W-1:0]       cnt, rj_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_sr <= '0;
      lr_sr  <= '0;
      sd_sr  <= '0;
    end else begin
      bck_sr <= {bck_sr[SYNC_STAGES-1:0], bit_clk};
      lr_sr  <= {lr_sr[SYNC_STAGES-1:0], frame_clk};
      sd_sr  <= {sd_sr[SYNC_STAGES-1:0], ser_data};
    end
  end

  assign bck_rise = bck_sr[SYNC_STAGES-1] & ~bck_sr[SYNC_STAGES];
  assign lr_now   = lr_sr[SYNC_STAGES-1];
  assign bit_now  = sd_sr[SYNC_STAGES-1];

  assign is_rj  = format[2];
  assign is_i2s = (format == 3'b001);

  assign eff_lr   = is_i2s ? lr_q1   : lr_now;
  assign eff_prev = is_i2s ? lr_q2   : lr_q1;
  assign eff_ok   = is_i2s ? seen[1] : seen[0];
  assign boundary = eff_ok && (eff_lr != eff_prev);

  always_comb begin
    case (format[1:0])
      2'b00:   rj_shift = CNT_W'(WORD_W - 24);
      2'b01:   rj_shift = CNT_W'(WORD_W - 20);
      2'b10:   rj_shift = CNT_W'(WORD_W - 18);
      default: rj_shift = CNT_W'(WORD_W - 16);
    endcase
    rj_tmp  = tail << rj_shift;
    rj_word = rj_tmp >>> rj_shift;
    lj_word = head << (CNT_W'(WORD_W) - cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q1     <= 1'b0;
      lr_q2     <= 1'b0;
      seen      <= '0;
      started   <= 1'b0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      pcm_word  <= '0;
      pcm_right <= 1'b0;
      pcm_valid <= 1'b0;
    end else begin
      pcm_valid <= 1'b0;
      if (bck_rise) begin
        lr_q1 <= lr_now;
        lr_q2 <= lr_q1;
        seen  <= {seen[0], 1'b1};
        tail  <= {tail[WORD_W-2:0], bit_now};
        if (boundary) begin
          started <= 1'b1;
          head    <= {{(WORD_W-1){1'b0}}, bit_now};
          cnt     <= CNT_W'(1);
          if (started) begin
            pcm_word  <= is_rj ? rj_word : lj_word;
            pcm_right <= is_i2s ? eff_prev : ~eff_prev;
            pcm_valid <= 1'b1;
          end
        end else if (cnt < CNT_W'(WORD_W)) begin
          head <= {head[WORD_W-2:0], bit_now};
          cnt  <= cnt + CNT_W'(1);
        end
      end
    end
  end

  logic have_prev, prev_tag;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_tag  <= 1'b0;
    end else if (pcm_valid) begin
      have_prev <= 1'b1;
      prev_tag  <= pcm_right;
    end
  end

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  assert_valid_follows_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(bck_rise));

  assert_tag_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && have_prev) |-> (pcm_right != prev_tag));

  assert_rj16_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && format == 3'b111) |->
      (pcm_word[WORD_W-1:15] == '0 || pcm_word[WORD_W-1:15] == '1));

  assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |=> (pcm_valid || $stable(pcm_word)));
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bit_clk = 0, frame_clk = 0, ser_data = 0;
  logic [2:0]  format = 3'b000;
  logic [23:0] pcm_word;
  logic        pcm_right, pcm_valid;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .format(format),
    .pcm_word(pcm_word), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] cap_w [32];
  logic        cap_r [32];
  int          cap_n = 0;
  bit          long_pulse = 0;
  logic        last_v = 0;
  logic        pend = 0;
  bit          cur_i2s = 0;

  always @(negedge clk) begin
    if (pcm_valid && last_v) long_pulse = 1;
    last_v = pcm_valid;
    if (pcm_valid && cap_n < 32) begin
      cap_w[cap_n] = pcm_word;
      cap_r[cap_n] = pcm_right;
      cap_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic lr);
    logic o;
    if (cur_i2s) begin o = pend; pend = b; end else o = b;
    repeat (4) @(posedge clk);
    frame_clk = lr;
    ser_data  = o;
    repeat (4) @(posedge clk);
    bit_clk = 1;
    repeat (4) @(posedge clk);
    ser_data = ~o;
    repeat (4) @(posedge clk);
    bit_clk = 0;
  endtask

  function automatic logic [23:0] val_for(int k, int ch, logic [23:0] seed, int wlen);
    logic [23:0] v, mask;
    mask = (24'h1 << wlen) - 24'h1;
    if (wlen == 24) mask = 24'hFFFFFF;
    v = (seed ^ (24'h5A3C96 * 24'(2 * k + ch + 1))) & mask;
    if (ch == 0) v[wlen-1] = 1'b1; else v[wlen-1] = 1'b0;
    return v;
  endfunction

  function automatic logic [23:0] exp_for(logic [23:0] v, bit rj, int wlen);
    logic [23:0] mask;
    mask = (wlen == 24) ? 24'hFFFFFF : ((24'h1 << wlen) - 24'h1);
    if (rj) return v[wlen-1] ? (v | ~mask) : v;
    return v << (24 - wlen);
  endfunction

  task automatic send_half(input logic [2:0] f, input bit left, input logic [23:0] v,
                           input int nbits, input int wlen);
    logic lr, b;
    bit rj;
    rj = f[2];
    lr = (f == 3'b001) ? ~left : left;
    for (int i = 0; i < nbits; i++) begin
      if (rj) b = (i >= nbits - wlen) ? v[wlen-1-(i-(nbits-wlen))] : 1'b1;
      else    b = (i < wlen) ? v[wlen-1-i] : 1'b1;
      put_bit(b, lr);
    end
  endtask

  task automatic do_reset(input logic [2:0] f);
    rst_n = 0; bit_clk = 0; ser_data = 0; format = f; pend = 0;
    cur_i2s = (f == 3'b001);
    frame_clk = cur_i2s ? 1'b1 : 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", pcm_valid, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 word after reset", pcm_word, 0);
    chk("R1 tag after reset", pcm_right, 0);
    chk("R1 valid after reset", pcm_valid, 0);
    cap_n = 0; long_pulse = 0;
  endtask

  task automatic run_case(input string req, input logic [2:0] f, input int nbits,
                          input int wlen, input int nfr, input bit partial,
                          input logic [23:0] seed);
    logic left_lvl;
    int e;
    bit rj;
    rj = f[2];
    do_reset(f);
    left_lvl = (f == 3'b001) ? 1'b0 : 1'b1;
    for (int i = 0; i < (partial ? 6 : 4); i++)
      put_bit(partial ? 1'b1 : 1'b0, partial ? left_lvl : ~left_lvl);
    for (int k = 0; k < nfr; k++) begin
      send_half(f, 1'b1, val_for(k, 0, seed, wlen), nbits, wlen);
      send_half(f, 1'b0, val_for(k, 1, seed, wlen), nbits, wlen);
    end
    send_half(f, 1'b1, 24'h0, 4, (wlen < 4) ? wlen : 4);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk({req, " word count"}, cap_n, 2 * nfr - (partial ? 1 : 0));
    e = 0;
    for (int k = 0; k < nfr; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (!(partial && k == 0 && ch == 0)) begin
          if (e < cap_n) begin
            chk({req, " data"}, cap_w[e], exp_for(val_for(k, ch, seed, wlen), rj, wlen));
            chk({req, " R8 tag"}, cap_r[e], ch);
          end
          e++;
        end
      end
    end
    chk({req, " R8 pulse width"}, long_pulse, 0);
  endtask

  task automatic test_lj24();    run_case("R3 R7 left-justified 24",  3'b000, 32, 24, 3, 0, 24'h1234AB); endtask
  task automatic test_alias();   run_case("R2 code 010 as left-just", 3'b010, 32, 24, 2, 0, 24'hC0FFEE); endtask
  task automatic test_alias3();  run_case("R2 code 011 as left-just", 3'b011, 32, 24, 2, 0, 24'h0F1E2D); endtask
  task automatic test_lj16();    run_case("R4 left-justified short",  3'b000, 16, 16, 3, 0, 24'h00BEEF); endtask
  task automatic test_i2s24();   run_case("R5 i2s 24",                3'b001, 32, 24, 3, 0, 24'h81C3E7); endtask
  task automatic test_i2s16();   run_case("R4 R5 i2s short",          3'b001, 16, 16, 3, 0, 24'h00A55A); endtask
  task automatic test_rj24();    run_case("R6 right-justified 24",    3'b100, 32, 24, 2, 0, 24'h3C5A69); endtask
  task automatic test_rj20();    run_case("R6 right-justified 20",    3'b101, 32, 20, 2, 0, 24'h0ABCDE); endtask
  task automatic test_rj18();    run_case("R6 right-justified 18",    3'b110, 32, 18, 2, 0, 24'h02F0F0); endtask
  task automatic test_rj16();    run_case("R6 right-justified 16",    3'b111, 32, 16, 2, 0, 24'h007E81); endtask
  task automatic test_partial(); run_case("R9 partial start",         3'b000, 32, 24, 2, 1, 24'h654321); endtask

  initial begin
    test_lj24();
    test_alias();
    test_alias3();
    test_lj16();
    test_i2s24();
    test_i2s16();
    test_rj24();
    test_rj20();
    test_rj18();
    test_rj16();
    test_partial();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule